// File: doc/BRIEF.md
# GPIO Bank Pad Control Registers

This block is the register file for one bank of general-purpose pins. Software reads and writes 32-bit words over a plain word bus (read strobe, write strobe, byte address). For each pin it stores an output level, a direction bit, a pull-enable bit and a pull-select bit, plus a two-bit drive-strength code. It turns those fields into registered per-pin controls for the pads: output enable, output value, pull-up, pull-down and drive code.

Pad input levels pass through a two-flop synchroniser and can be read back from a read-only word. The pin count is a parameter, up to 32. Bits for pins that do not exist read as zero and cannot be written.

Top module: `gpio_padctl_bank`

## Requirements
- R1: After a synchronous reset, every direction bit reads 1 (input), and the output, pull-enable, pull-select and drive-strength fields read 0. The pad output enables and drive codes are 0.
- R2: Word indices are fixed: 0 pad input, 1 output level, 2 direction, 3 pull enable, 4 pull select, 7 and up drive strength. The byte address is the word index times 4, and address bits [1:0] are ignored. A word written at a mapped writable index reads back the written value, masked to existing pins.
- R3: Direction bit n sits at bit n. A 1 makes pin n an input and a 0 makes it an output. `pad_oe[n]` is the inverse of that bit and is valid the cycle after the write.
- R4: Output bit n sits at bit n and drives `pad_out[n]` from the cycle after the write.
- R5: When pull-enable bit n is 0, pin n has no bias: `pad_pull_up[n]` and `pad_pull_dn[n]` are both 0, whatever the pull-select bit holds. When it is 1, pull-select 1 gives pull-up and 0 gives pull-down. The pull outputs follow the register fields one cycle later.
- R6: The drive code of pin n is two bits at bit (2n mod 32) of word 7 + (2n / 32). Codes 0 to 3 run from weakest (500 uA) to strongest (4000 uA). Pin n's code appears on `pad_drive[2n+1:2n]`.
- R7: Word 0 returns the pad levels after a two-flop synchroniser. A level change before clock edge k is returned by a read whose strobe is sampled at edge k+2 or later. Writes to word 0 are ignored.
- R8: Reads from unmapped words (5, 6, and indices past the last drive word) return zero. Writes to them change no register.
- R9: Register bits above the pin count read as zero and cannot be written. This applies to each drive word as well.
- R10: Read data is registered. `bus_rdata` holds the selected word in the cycle after a read strobe and is zero in the cycle after any cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | PIN_COUNT | Asynchronous pad input levels |
| pad_oe | output | PIN_COUNT | Per-pin output enable |
| pad_out | output | PIN_COUNT | Per-pin output level |
| pad_pull_up | output | PIN_COUNT | Per-pin pull-up request |
| pad_pull_dn | output | PIN_COUNT | Per-pin pull-down request |
| pad_drive | output | 2*PIN_COUNT | Two-bit drive code per pin |

## Verification
The hardest case to reach from the ports is the upper edge of the drive-strength map. There, a second word is only partly populated, and a write to it must touch exactly the codes of the top pins and nothing else. The bench therefore uses a 20-pin bank. With 20 pins, word 8 carries four codes in its low byte. The bench writes all ones to that word and checks that the read-back holds only that byte, then places distinct codes in it and observes them on the top pins' drive outputs. Synchroniser latency is checked by changing the pad levels while a read strobe is held. The bench then checks that the old value is still returned two edges later and the new one on the third edge.

// File: rtl/gpio_padctl_pkg.sv
package gpio_padctl_pkg;

  // Word indices of the register map (byte address = index * 4)
  localparam int unsigned WIDX_IN   = 0;
  localparam int unsigned WIDX_OUT  = 1;
  localparam int unsigned WIDX_DIR  = 2;
  localparam int unsigned WIDX_PEN  = 3;
  localparam int unsigned WIDX_PSEL = 4;
  localparam int unsigned WIDX_DRV0 = 7;

  // Drive-strength codes, weakest to strongest
  typedef enum logic [1:0] {
    DRV_500UA  = 2'd0,
    DRV_2500UA = 2'd1,
    DRV_3000UA = 2'd2,
    DRV_4000UA = 2'd3
  } drive_code_e;

  function automatic int unsigned drv_words(input int unsigned pins);
    return (2 * pins + 31) / 32;
  endfunction

  function automatic logic [31:0] low_mask(input int unsigned n);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/padctl_sync.sv
module padctl_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/padctl_field.sv
// One bit per pin register field. STORE_INV keeps the flop in the
// polarity the pad wants while the bus sees the inverse.
module padctl_field #(
  parameter int unsigned W         = 32,
  parameter bit          STORE_INV = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [31:0]  wdata,
  output logic [W-1:0] store_q,
  output logic [31:0]  rb
);
  logic [W-1:0] wr_bits;
  logic [W-1:0] view;

  assign wr_bits = STORE_INV ? ~wdata[W-1:0] : wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     store_q <= '0;
    else if (we) store_q <= wr_bits;
  end

  assign view = STORE_INV ? ~store_q : store_q;
  assign rb   = 32'(view);
endmodule

// File: rtl/padctl_drive.sv
// Packed two-bit drive codes, spread over consecutive bus words.
module padctl_drive #(
  parameter int unsigned PINS = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [gpio_padctl_pkg::drv_words(PINS)-1:0] we,
  input  logic [31:0]                      wdata,
  output logic [2*PINS-1:0]                drv_q,
  output logic [gpio_padctl_pkg::drv_words(PINS)-1:0][31:0] rb
);
  localparam int unsigned NBITS  = 2 * PINS;
  localparam int unsigned NWORDS = gpio_padctl_pkg::drv_words(PINS);
  localparam int unsigned FLATW  = 32 * NWORDS;

  logic [NBITS-1:0] drv_d;
  logic [FLATW-1:0] flat;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    assign drv_d[b] = we[b / 32] ? wdata[b % 32] : drv_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= '0;
    else     drv_q <= drv_d;
  end

  assign flat = FLATW'(drv_q);

  for (genvar k = 0; k < NWORDS; k++) begin : g_rb
    assign rb[k] = flat[k*32 +: 32];
  end
endmodule

// File: rtl/gpio_padctl_bank.sv
module gpio_padctl_bank #(
  parameter int unsigned PIN_COUNT = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [PIN_COUNT-1:0]   pad_in,
  output logic [PIN_COUNT-1:0]   pad_oe,
  output logic [PIN_COUNT-1:0]   pad_out,
  output logic [PIN_COUNT-1:0]   pad_pull_up,
  output logic [PIN_COUNT-1:0]   pad_pull_dn,
  output logic [2*PIN_COUNT-1:0] pad_drive
);
  import gpio_padctl_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned NDRV   = drv_words(PIN_COUNT);

  logic [WORD_W-1:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  logic hit_out, hit_dir, hit_pen, hit_psel, hit_in;
  assign hit_in   = (widx == WORD_W'(WIDX_IN));
  assign hit_out  = (widx == WORD_W'(WIDX_OUT));
  assign hit_dir  = (widx == WORD_W'(WIDX_DIR));
  assign hit_pen  = (widx == WORD_W'(WIDX_PEN));
  assign hit_psel = (widx == WORD_W'(WIDX_PSEL));

  logic [NDRV-1:0] hit_drv;
  for (genvar k = 0; k < NDRV; k++) begin : g_drvhit
    assign hit_drv[k] = (widx == WORD_W'(WIDX_DRV0 + k));
  end

  // Pad input synchroniser
  logic [PIN_COUNT-1:0] in_sync;
  padctl_sync #(.W(PIN_COUNT)) sync_i (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(in_sync)
  );

  // Per-pin single-bit fields
  logic [31:0] rb_out, rb_dir, rb_pen, rb_psel;
  logic [PIN_COUNT-1:0] pen_q, psel_q;

  padctl_field #(.W(PIN_COUNT), .STORE_INV(1'b0)) out_i (
    .clk(clk), .rst(rst), .we(bus_wr && hit_out), .wdata(bus_wdata),
    .store_q(pad_out), .rb(rb_out)
  );

  // Direction is stored as output enable (1 = drive), read as 1 = input
  padctl_field #(.W(PIN_COUNT), .STORE_INV(1'b1)) dir_i (
    .clk(clk), .rst(rst), .we(bus_wr && hit_dir), .wdata(bus_wdata),
    .store_q(pad_oe), .rb(rb_dir)
  );

  padctl_field #(.W(PIN_COUNT), .STORE_INV(1'b0)) pen_i (
    .clk(clk), .rst(rst), .we(bus_wr && hit_pen), .wdata(bus_wdata),
    .store_q(pen_q), .rb(rb_pen)
  );

  padctl_field #(.W(PIN_COUNT), .STORE_INV(1'b0)) psel_i (
    .clk(clk), .rst(rst), .we(bus_wr && hit_psel), .wdata(bus_wdata),
    .store_q(psel_q), .rb(rb_psel)
  );

  // Drive strength words
  logic [NDRV-1:0][31:0] rb_drv;
  padctl_drive #(.PINS(PIN_COUNT)) drv_i (
    .clk(clk), .rst(rst), .we(hit_drv & {NDRV{bus_wr}}), .wdata(bus_wdata),
    .drv_q(pad_drive), .rb(rb_drv)
  );

  // Pull request stage: select only matters while enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_pull_up <= '0;
      pad_pull_dn <= '0;
    end else begin
      pad_pull_up <= pen_q &  psel_q;
      pad_pull_dn <= pen_q & ~psel_q;
    end
  end

  // Read multiplexer: OR of one-hot selected words
  logic [NDRV:0][31:0] drv_acc;
  assign drv_acc[0] = '0;
  for (genvar k = 0; k < NDRV; k++) begin : g_drvrd
    assign drv_acc[k+1] = drv_acc[k] | (hit_drv[k] ? rb_drv[k] : 32'd0);
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = drv_acc[NDRV];
    if (hit_in)   rd_val = rd_val | 32'(in_sync);
    if (hit_out)  rd_val = rd_val | rb_out;
    if (hit_dir)  rd_val = rd_val | rb_dir;
    if (hit_pen)  rd_val = rd_val | rb_pen;
    if (hit_psel) rd_val = rd_val | rb_psel;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/padctl_chk.sv
module padctl_chk #(
  parameter int unsigned PIN_COUNT = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [PIN_COUNT-1:0]   pad_oe,
  input logic [PIN_COUNT-1:0]   pad_out,
  input logic [PIN_COUNT-1:0]   pad_pull_up,
  input logic [PIN_COUNT-1:0]   pad_pull_dn,
  input logic [2*PIN_COUNT-1:0] pad_drive
);
  import gpio_padctl_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned NDRV   = drv_words(PIN_COUNT);
  localparam logic [31:0] PMASK  = low_mask(PIN_COUNT);

  logic [WORD_W-1:0] w;
  logic unmapped, single_bit_word;
  assign w = bus_addr[ADDR_W-1:2];
  assign unmapped = (w == WORD_W'(5)) || (w == WORD_W'(6)) ||
                    (32'(w) >= WIDX_DRV0 + NDRV);
  assign single_bit_word = (32'(w) <= WIDX_PSEL);

  // R1: reset clears output enables and drive codes
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0) && (pad_drive == '0) && (bus_rdata == '0));

  // R3: output enable is the inverse of the written direction bits
  assert_dir_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && w == WORD_W'(WIDX_DIR)) |=>
      (pad_oe == ~$past(bus_wdata[PIN_COUNT-1:0])));

  // R4: output level follows the written output bits
  assert_out_level_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && w == WORD_W'(WIDX_OUT)) |=>
      (pad_out == $past(bus_wdata[PIN_COUNT-1:0])));

  // R5: a pin never requests both pulls
  assert_pull_excl_R5: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_up & pad_pull_dn) == '0);

  // R8: unmapped reads return zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> (bus_rdata == '0));

  // R9: bits above the pin count read zero
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && single_bit_word) |=> ((bus_rdata & ~PMASK) == '0));

  // R10: no read strobe, zero read data
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind gpio_padctl_bank padctl_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
  .pad_out(pad_out), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
  .pad_drive(pad_drive)
);

// File: tb/gpio_padctl_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_padctl_bank_tb_top;
  localparam int unsigned PINS = 20;
  localparam int unsigned AW   = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [PINS-1:0]   pad_in = 20'h0ACE1;
  logic [PINS-1:0]   pad_oe, pad_out, pad_pull_up, pad_pull_dn;
  logic [2*PINS-1:0] pad_drive;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_padctl_bank #(.PIN_COUNT(PINS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_drive(pad_drive)
  );

  typedef struct packed {
    logic [3:0]  word;
    logic [31:0] wdata;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  // write word, then read it back and compare
  localparam vec_t VECS [11] = '{
    '{4'd1, 32'hFFFF_FFFF, 32'h000F_FFFF, 4'd9},  // R9 output word masked
    '{4'd1, 32'h0005_A5A5, 32'h0005_A5A5, 4'd2},  // R2
    '{4'd2, 32'h0001_2345, 32'h0001_2345, 4'd2},  // R2
    '{4'd3, 32'h000A_BCDE, 32'h000A_BCDE, 4'd2},  // R2
    '{4'd4, 32'h0005_5555, 32'h0005_5555, 4'd2},  // R2
    '{4'd7, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd6},  // R6 pins 0..15
    '{4'd8, 32'hFFFF_FFFF, 32'h0000_00FF, 4'd9},  // R9 pins 16..19 only
    '{4'd5, 32'h0000_1234, 32'h0000_0000, 4'd8},  // R8
    '{4'd6, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},  // R8
    '{4'd0, 32'h000F_FFFF, 32'h0000_ACE1, 4'd7},  // R7 write ignored
    '{4'd9, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8}   // R8 past last drive word
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {w, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_word(input logic [3:0] w, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = {w, 2'b00};
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pad_oe", 64'(pad_oe), 64'h0);
    check("R1 pad_drive", 64'(pad_drive), 64'h0);
    rd_word(4'd2, v); check("R1 direction", 64'(v), 64'h000F_FFFF);
    rd_word(4'd1, v); check("R1 output", 64'(v), 64'h0);
    rd_word(4'd3, v); check("R1 pull enable", 64'(v), 64'h0);
    rd_word(4'd7, v); check("R1 drive", 64'(v), 64'h0);

    // Table of write/read-back vectors
    for (int i = 0; i < 11; i++) begin
      wr_word(VECS[i].word, VECS[i].wdata);
      rd_word(VECS[i].word, v);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(v), 64'(VECS[i].expv));
    end

    // R8 writes to unmapped words change nothing
    wr_word(4'd5, 32'hFFFF_FFFF);
    wr_word(4'd15, 32'h0000_0000);
    rd_word(4'd1, v); check("R8 output intact", 64'(v), 64'h0005_A5A5);
    rd_word(4'd3, v); check("R8 pull enable intact", 64'(v), 64'h000A_BCDE);
    rd_word(4'd8, v); check("R8 drive word intact", 64'(v), 64'h0000_00FF);

    // R3 direction -> output enable
    wr_word(4'd2, 32'h000F_FFF0);
    check("R3 pad_oe", 64'(pad_oe), 64'h0000_000F);

    // R4 output level
    wr_word(4'd1, 32'h0008_0001);
    check("R4 pad_out", 64'(pad_out), 64'h0008_0001);

    // R5 pulls: pin0 up, pin1 down, pin2 select set but disabled
    wr_word(4'd3, 32'h0000_0003);
    wr_word(4'd4, 32'h0000_0005);
    @(negedge clk);
    check("R5 pull up", 64'(pad_pull_up), 64'h1);
    check("R5 pull down", 64'(pad_pull_dn), 64'h2);

    // R6 drive codes: pins 0..3 codes 0,1,2,3; pins 16,19 code 3
    wr_word(4'd7, 32'h0000_00E4);
    check("R6 low word", 64'(pad_drive[31:0]), 64'h0000_00E4);
    wr_word(4'd8, 32'h0000_00C3);
    check("R6 top pins", 64'(pad_drive[39:32]), 64'h0000_00C3);

    // R7 synchroniser latency while holding a read strobe
    @(negedge clk);
    pad_in = 20'h00F0F; bus_rd = 1'b1; bus_addr = {4'd0, 2'b00};
    @(negedge clk);
    @(negedge clk);
    check("R7 old level after two edges", 64'(bus_rdata), 64'h0000_ACE1);
    @(negedge clk);
    check("R7 new level on third edge", 64'(bus_rdata), 64'h0000_0F0F);
    bus_rd = 1'b0;

    // R10 idle read data
    @(negedge clk);
    check("R10 idle rdata", 64'(bus_rdata), 64'h0);

    finish_run();
  end
endmodule